// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of an interval timer. It holds a 16-bit down-counter that moves only on cycles where the `tick` input is high. The channel drives a single output line. Its shape depends on an operating mode picked from six: a terminal-count flag, a gate-triggered one-shot, a periodic rate pulse, a square wave, a strobe started by loading, and a strobe started by the gate.

A host loads the channel by pulsing `load_strobe`, which captures both `mode_sel` and `load_value` in the same cycle. From then until the count has been moved into the counter, `null_count` stays high. The count moves into the counter on the next tick in modes 0, 2, 3 and 4, and on the trigger tick in modes 1 and 5. The live counter value is always visible on `count_now`, so an outside latch path can take a snapshot of it. The `gate` input does different jobs depending on the mode: in some modes it enables counting, and in others its rising edge acts as a trigger. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `interval_counter_channel`

## Requirements
- R1: After reset, `out` is 1, `null_count` is 0 and `count_now` is 0.
- R2: A load sets `null_count` to 1 from the next cycle. It falls to 0 on the tick that moves the count into the counter, and from that tick on `count_now` shows the loaded value.
- R3: Mode 0 (code 000): a load drives `out` to 0. With `gate` high, `out` rises on the Nth tick after the transfer tick and then stays 1 until the next load.
- R4: In modes 0, 2 and 3, ticks that arrive while `gate` is low leave `count_now` and `out` unchanged.
- R5: Mode 1 (code 001): `out` stays 1 until a rising edge of `gate`. The next tick loads the counter and drives `out` low for exactly N ticks.
- R6: Mode 2 (code 010), N>=2: `out` goes low for one tick when the count reaches 1. The counter then reloads, so after the k-th tick following the load `out` equals (k mod N != 0).
- R7: In modes 2 and 3, a rising edge of `gate` makes the next tick restart the count from the reload value with `out` high.
- R8: Mode 3 (code 011), N>=2: after the k-th tick, `out` is 1 exactly when ((k-1) mod N) < (N+1)/2. This gives (N+1)/2 ticks high and N/2 ticks low per period.
- R9: Mode 4 (code 100): `out` is low only after tick N+1 counted from the load, and only for that one tick. The counter then stays at 0 and does not reload.
- R10: Mode 5 (code 101): the first tick after a rising edge of `gate` starts the count. The count goes on even if `gate` falls. `out` is low for one tick only, N ticks after the start tick.
- R11: Mode codes 110 and 111 behave exactly like codes 010 and 011.
- R12: A loaded count of 0 stands for 65536. In mode 4, `out` goes low on tick 65537 after the load.
- R13: Cycles with `tick` low and no load leave `count_now` and `out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one pulse per counting clock |
| gate | input | 1 | Gate level / trigger input |
| load_strobe | input | 1 | Capture mode and count |
| mode_sel | input | 3 | Operating mode code |
| load_value | input | 16 | Count value, 0 meaning 65536 |
| out | output | 1 | Channel output line |
| count_now | output | 16 | Present counter value |
| null_count | output | 1 | Loaded count not yet in the counter |

## Verification
The bench builds the channel with its default 16-bit counter. This lets a load of 0 in strobe mode run the full 65536-count interval and check wrap handling at the real width. For every mode, it sweeps the loaded count over small values (1 to 8) and compares the output after each tick with a closed-form phase formula. That sweep covers every odd/even split of the square wave and the shortest rate periods. Gate lowering, gate retriggering and the two undefined mode codes are exercised at chosen points within those sweeps.

// File: rtl/icc_pkg.sv
package icc_pkg;
  typedef enum logic [2:0] {
    MODE_TC        = 3'd0,
    MODE_ONESHOT   = 3'd1,
    MODE_RATE      = 3'd2,
    MODE_SQUARE    = 3'd3,
    MODE_SW_STROBE = 3'd4,
    MODE_HW_STROBE = 3'd5
  } icc_mode_e;

  // codes 6 and 7 fold onto the periodic modes by dropping the top bit
  function automatic icc_mode_e icc_norm_mode(input logic [2:0] code);
    if (code[2] && code[1]) return icc_mode_e'({1'b0, code[1:0]});
    return icc_mode_e'(code);
  endfunction
endpackage

// File: rtl/icc_gate_edge.sv
module icc_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic consume,
  input  logic clear,
  output logic trig
);
  logic gate_q, pend_q, pend_d, rise;

  assign rise = gate & ~gate_q;
  assign trig = pend_q | rise;

  always_comb begin
    pend_d = pend_q | rise;
    if (clear || consume) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      gate_q <= gate;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/icc_half_split.sv
module icc_half_split #(
  parameter int W = 16
) (
  input  logic [W-1:0] reload,
  output logic [W-1:0] hi_len,
  output logic [W-1:0] lo_len
);
  localparam logic [W-1:0] HALF_WRAP = W'(1) << (W - 1);
  logic zero_ld;

  assign zero_ld = (reload == '0);
  assign hi_len  = zero_ld ? HALF_WRAP : (reload >> 1) + {{(W-1){1'b0}}, reload[0]};
  assign lo_len  = zero_ld ? HALF_WRAP : (reload >> 1);
endmodule

// File: rtl/interval_counter_channel.sv
module interval_counter_channel
  import icc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate,
  input  logic             load_strobe,
  input  logic [2:0]       mode_sel,
  input  logic [CNT_W-1:0] load_value,
  output logic             out,
  output logic [CNT_W-1:0] count_now,
  output logic             null_count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  icc_mode_e        mode_q, mode_d;
  logic [CNT_W-1:0] reload_q, reload_d, cnt_q, cnt_d, hi_len, lo_len;
  logic             out_q, out_d, run_q, run_d, pend_q, pend_d, trig;

  icc_gate_edge u_edge (
    .clk(clk), .rst_n(rst_sn), .gate(gate),
    .consume(tick), .clear(load_strobe), .trig(trig)
  );

  icc_half_split #(.W(CNT_W)) u_split (
    .reload(reload_q), .hi_len(hi_len), .lo_len(lo_len)
  );

  always_comb begin
    mode_d = mode_q; reload_d = reload_q; cnt_d = cnt_q;
    out_d = out_q; run_d = run_q; pend_d = pend_q;
    if (load_strobe) begin
      mode_d   = icc_norm_mode(mode_sel);
      reload_d = load_value;
      pend_d   = 1'b1;
      run_d    = 1'b0;
      out_d    = (icc_norm_mode(mode_sel) != MODE_TC);
    end else if (tick) begin
      case (mode_q)
        MODE_TC: begin
          if (pend_q) begin
            cnt_d = reload_q; pend_d = 1'b0; run_d = 1'b1;
          end else if (run_q && gate) begin
            cnt_d = cnt_q - ONE;
            if (cnt_q == ONE) out_d = 1'b1;
          end
        end
        MODE_ONESHOT: begin
          if (trig) begin
            cnt_d = reload_q; out_d = 1'b0; run_d = 1'b1; pend_d = 1'b0;
          end else if (run_q) begin
            cnt_d = cnt_q - ONE;
            if (cnt_q == ONE) begin out_d = 1'b1; run_d = 1'b0; end
          end
        end
        MODE_RATE: begin
          if (pend_q || trig) begin
            cnt_d = reload_q; pend_d = 1'b0; out_d = 1'b1;
          end else if (gate) begin
            if (cnt_q == TWO)      begin cnt_d = ONE;      out_d = 1'b0; end
            else if (cnt_q == ONE) begin cnt_d = reload_q; out_d = 1'b1; end
            else                   cnt_d = cnt_q - ONE;
          end
        end
        MODE_SQUARE: begin
          if (pend_q || trig) begin
            cnt_d = hi_len; pend_d = 1'b0; out_d = 1'b1;
          end else if (gate) begin
            if (cnt_q == ONE) begin
              out_d = ~out_q;
              cnt_d = out_q ? lo_len : hi_len;
            end else cnt_d = cnt_q - ONE;
          end
        end
        MODE_SW_STROBE, MODE_HW_STROBE: begin
          if (!out_q) out_d = 1'b1;
          if ((mode_q == MODE_SW_STROBE) ? pend_q : trig) begin
            cnt_d = reload_q; pend_d = 1'b0; run_d = 1'b1;
          end else if (run_q) begin
            if (cnt_q == ONE) begin cnt_d = '0; out_d = 1'b0; run_d = 1'b0; end
            else cnt_d = cnt_q - ONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      mode_q <= MODE_TC; reload_q <= '0; cnt_q <= '0;
      out_q <= 1'b1; run_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      mode_q <= mode_d; reload_q <= reload_d; cnt_q <= cnt_d;
      out_q <= out_d; run_q <= run_d; pend_q <= pend_d;
    end
  end

  assign out        = out_q;
  assign count_now  = cnt_q;
  assign null_count = pend_q;

  p_load_sets_null_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    load_strobe |=> null_count);
  p_tc_out_holds_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (mode_q == MODE_TC) && out_q && !load_strobe |=> out_q);
  p_gate_low_freeze_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (mode_q == MODE_TC) && !gate && !pend_q && !load_strobe |=> $stable(cnt_q));
  p_rate_low_at_one_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (mode_q == MODE_RATE) && !out_q |-> (cnt_q == ONE));
  p_strobe_one_tick_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    ((mode_q == MODE_SW_STROBE) || (mode_q == MODE_HW_STROBE)) && !out_q && tick && !load_strobe
    |=> out_q);
  p_alias_code_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    load_strobe && (mode_sel == 3'b110) |=> (mode_q == MODE_RATE));
  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_sn)
    !tick && !load_strobe |=> $stable(cnt_q) && $stable(out_q));
endmodule

// File: tb/test_interval_counter_channel.sv
module test_interval_counter_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, gate = 1'b0, load_strobe = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic [15:0] load_value = 16'd0;
  logic        out, null_count;
  logic [15:0] count_now;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  interval_counter_channel i_interval_counter_channel (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .load_strobe(load_strobe),
    .mode_sel(mode_sel), .load_value(load_value), .out(out),
    .count_now(count_now), .null_count(null_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick1();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  task automatic load_ch(input logic [2:0] m, input logic [15:0] v);
    mode_sel = m; load_value = v; load_strobe = 1'b1;
    @(negedge clk); load_strobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(3);
    check("R1 out", out, 1); check("R1 null", null_count, 0); check("R1 count", count_now, 0);

    // R3 / R2: mode 0 sweep
    gate = 1'b1; idle(2);
    for (int n = 1; n <= 6; n++) begin
      load_ch(3'd0, 16'(n));
      check("R3 out after load", out, 0); check("R2 null set", null_count, 1);
      for (int k = 1; k <= n + 2; k++) begin
        tick1();
        check("R3 out", out, (k > n) ? 1 : 0);
        if (k == 1) begin check("R2 null clear", null_count, 0); check("R2 count", count_now, n); end
      end
    end
    // R4 / R13 in mode 0
    load_ch(3'd0, 16'd5); gate = 1'b0; tick1();
    for (int k = 0; k < 8; k++) tick1();
    check("R4 count held", count_now, 5); check("R4 out held", out, 0);
    idle(4); check("R13 count idle", count_now, 5);
    gate = 1'b1;
    for (int k = 0; k < 5; k++) tick1();
    check("R4 resumes", out, 1);

    // R5: mode 1
    for (int n = 1; n <= 5; n++) begin
      gate = 1'b0; idle(1); load_ch(3'd1, 16'(n));
      tick1(); tick1(); check("R5 idle out", out, 1); check("R5 idle null", null_count, 1);
      gate = 1'b1; idle(1);
      for (int k = 1; k <= n + 2; k++) begin
        tick1(); check("R5 out", out, (k > n) ? 1 : 0);
      end
    end

    // R6: mode 2, R11: code 6
    for (int n = 2; n <= 6; n++) begin
      load_ch((n == 3) ? 3'd6 : 3'd2, 16'(n));
      for (int k = 1; k <= 3 * n; k++) begin
        tick1(); check((n == 3) ? "R11 code6" : "R6 rate", out, (k % n != 0) ? 1 : 0);
      end
    end
    // R7 / R4 in mode 2
    load_ch(3'd2, 16'd4); tick1(); tick1(); tick1();
    check("R6 count", count_now, 2);
    gate = 1'b0; idle(1); tick1(); tick1();
    check("R4 rate held", count_now, 2); check("R4 rate out", out, 1);
    gate = 1'b1; idle(1); tick1();
    check("R7 restart count", count_now, 4); check("R7 restart out", out, 1);
    tick1(); tick1(); tick1(); check("R7 low after restart", out, 0);

    // R8: mode 3, R11: code 7
    for (int n = 2; n <= 8; n++) begin
      load_ch((n == 5) ? 3'd7 : 3'd3, 16'(n));
      for (int k = 1; k <= 3 * n; k++) begin
        tick1();
        check((n == 5) ? "R11 code7" : "R8 square", out, (((k - 1) % n) < (n + 1) / 2) ? 1 : 0);
      end
    end
    // R7 in mode 3
    load_ch(3'd3, 16'd6); tick1(); tick1(); tick1(); tick1();
    check("R8 low half", out, 0);
    gate = 1'b0; idle(1); gate = 1'b1; idle(1); tick1();
    check("R7 square restart", out, 1); check("R7 square count", count_now, 3);

    // R9: mode 4
    for (int n = 1; n <= 6; n++) begin
      load_ch(3'd4, 16'(n));
      for (int k = 1; k <= n + 4; k++) begin
        tick1(); check("R9 strobe", out, (k == n + 1) ? 0 : 1);
      end
      check("R9 no reload", count_now, 0);
    end

    // R10: mode 5
    for (int n = 1; n <= 5; n++) begin
      gate = 1'b0; idle(1); load_ch(3'd5, 16'(n));
      tick1(); tick1(); check("R10 waits", out, 1); check("R10 null", null_count, 1);
      gate = 1'b1; idle(1); tick1();
      check("R10 start count", count_now, n);
      gate = 1'b0;
      for (int k = 2; k <= n + 3; k++) begin
        tick1(); check("R10 strobe", out, (k == n + 1) ? 0 : 1);
      end
    end

    // R12: zero count in mode 4
    begin
      int seen;
      seen = 0;
      load_ch(3'd4, 16'd0);
      for (int k = 1; k <= 65540; k++) begin
        tick1();
        if (!out && seen == 0) seen = k;
      end
      check("R12 wrap length", seen, 65537);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule